// File: doc/BRIEF.md
# Priority-Based Reference Selection Controller

This controller decides which of two clock references, A or B, drives a downstream loop. It also decides when that loop should coast in holdover or run free. Each reference arrives with a validity flag from an external monitor and a programmable priority. A three-bit mode field picks one of five selection policies: two fully automatic ones and three that follow a user-chosen reference.

Two force bits override the policy. One forces holdover and the other forces free run, and free run takes precedence when both are set. All outputs are registered, so a decision is visible one clock after the inputs that caused it. A single-cycle pulse marks every change of the active reference. The block only decides; it does not qualify references, align phase or compute holdover frequency.

Mode codes are: 0 automatic revertive, 1 automatic non-revertive, 2 manual with automatic fallback, 3 manual with holdover, 4 manual fixed. Codes 5 to 7 behave as code 0. With the default `SMALL_IS_HIGH = 1`, a numerically smaller priority value means a higher priority. On `sel_b`, `user_sel_b` and the internal index, 0 means reference A and 1 means reference B.

Top module: `refsel_ctrl`

## Requirements
- R1: While `rst_n` is low, `sel_b`, `in_holdover`, `in_freerun` and `switch_pulse` are all 0 (reference A active, neither holdover nor free run).
- R2: In modes 0 and 1, when only one reference is valid, or one valid reference has a strictly higher priority, that reference is selected; `user_sel_b` has no effect.
- R3: In mode 0, when a reference with strictly higher priority than the active one becomes valid, the block switches to it even though the active reference is still valid.
- R4: When both references are valid with equal priority, the block stays on the currently active reference; position alone never causes a switch.
- R5: When a fresh choice is made between two valid references of equal priority (the previous cycle was in holdover or free run), reference A is chosen.
- R6: In mode 1, the active reference is kept while it stays valid, even when the other reference is valid with higher priority. When it becomes invalid, the block moves to the other reference if that one is valid.
- R7: In mode 2, the user reference is used while it is valid, whatever its priority. When it is invalid, automatic selection applies, including holdover when neither reference is valid. When it becomes valid again, the block returns to it.
- R8: In mode 3, the user reference is used while it is valid. When it is invalid, `in_holdover` rises and `sel_b` keeps its last value, even if the other reference is valid.
- R9: In mode 4, `sel_b` follows `user_sel_b` regardless of validity, and `in_holdover` stays 0.
- R10: `force_free` drives `in_freerun` high and `in_holdover` low, also when `force_hold` is set. `in_holdover` and `in_freerun` are never high together.
- R11: `force_hold` without `force_free` drives `in_holdover` high. While either force bit is set, `sel_b` does not change.
- R12: In modes 0 and 1, when neither reference is valid, `in_holdover` rises and `sel_b` keeps the last active reference.
- R13: `switch_pulse` is high for exactly the cycle in which `sel_b` differs from its previous value. All outputs update one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_a | input | 1 | Reference A is qualified |
| valid_b | input | 1 | Reference B is qualified |
| prio_a | input | PRIO_W | Priority of reference A |
| prio_b | input | PRIO_W | Priority of reference B |
| user_sel_b | input | 1 | User-chosen reference (0 = A, 1 = B) |
| mode | input | 3 | Selection policy code |
| force_hold | input | 1 | Force holdover |
| force_free | input | 1 | Force free run |
| sel_b | output | 1 | Active reference (0 = A, 1 = B) |
| in_holdover | output | 1 | Holdover state |
| in_freerun | output | 1 | Free-run state |
| switch_pulse | output | 1 | One-cycle pulse on active reference change |

## Verification
The bench targets equal-priority cases where two valid references compete. A design that applied the positional tie-break on every cycle would jump from B to A with a spurious pulse. A design that never applied it would resume on B after a forced holdover instead of on A.

Non-revertive and revertive behaviour are checked against the same priority pattern. Swapping them shows up as a missing or an unwanted switch. Manual-with-holdover is driven with the other reference valid, so a design that fell back instead of holding would change `sel_b`.

Both force bits are set together to expose a wrong precedence. Priorities are changed while forced to catch a design that keeps selecting underneath the override.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_AUTO_REV    = 3'd0,
      MODE_AUTO_NONREV = 3'd1,
      MODE_MAN_FALLBK  = 3'd2,
      MODE_MAN_HOLD    = 3'd3,
      MODE_MAN_FIXED   = 3'd4
   } sel_mode_e;

   typedef struct packed {
      logic ref_b;
      logic hold;
      logic free;
   } sel_state_t;

endpackage

// File: rtl/refsel_rank.sv
`timescale 1ns/1ps
// Strict priority comparison of the two references; polarity chosen by parameter.
module refsel_rank #(
   parameter int PRIO_W        = 4,
   parameter bit SMALL_IS_HIGH = 1'b1
) (
   input  logic [PRIO_W-1:0] prio_a,
   input  logic [PRIO_W-1:0] prio_b,
   output logic              a_higher,
   output logic              b_higher
);

   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_width
      $error("refsel_rank: PRIO_W must be within 1..16");
   end

   if (SMALL_IS_HIGH) begin : g_small_high
      assign a_higher = (prio_a < prio_b);
      assign b_higher = (prio_b < prio_a);
   end else begin : g_large_high
      assign a_higher = (prio_a > prio_b);
      assign b_higher = (prio_b > prio_a);
   end

endmodule

// File: rtl/refsel_policy.sv
`timescale 1ns/1ps
// Combinational next-state decision for all five selection policies and overrides.
module refsel_policy
   import refsel_pkg::*;
(
   input  logic              valid_a,
   input  logic              valid_b,
   input  logic              a_higher,
   input  logic              b_higher,
   input  logic              user_sel_b,
   input  logic [MODE_W-1:0] mode,
   input  logic              force_hold,
   input  logic              force_free,
   input  logic              cur_b,
   input  logic              cur_idle,
   output sel_state_t        nxt
);

   logic auto_b;
   logic auto_hold;
   logic user_ok;
   logic cur_ok;

   // Automatic candidate: strict priority first, then stay, then position A.
   always_comb begin
      auto_b    = cur_b;
      auto_hold = 1'b0;
      if (valid_a && valid_b) begin
         if (b_higher)      auto_b = 1'b1;
         else if (a_higher) auto_b = 1'b0;
         else if (cur_idle) auto_b = 1'b0;
         else               auto_b = cur_b;
      end else if (valid_a) begin
         auto_b = 1'b0;
      end else if (valid_b) begin
         auto_b = 1'b1;
      end else begin
         auto_hold = 1'b1;
      end
   end

   assign user_ok = user_sel_b ? valid_b : valid_a;
   assign cur_ok  = cur_b      ? valid_b : valid_a;

   always_comb begin
      nxt.ref_b = cur_b;
      nxt.hold  = 1'b0;
      nxt.free  = 1'b0;
      if (force_free) begin
         nxt.free = 1'b1;
      end else if (force_hold) begin
         nxt.hold = 1'b1;
      end else begin
         case (mode)
            MODE_AUTO_NONREV: begin
               if (cur_ok && !cur_idle) begin
                  nxt.ref_b = cur_b;
               end else begin
                  nxt.ref_b = auto_b;
                  nxt.hold  = auto_hold;
               end
            end
            MODE_MAN_FALLBK: begin
               if (user_ok) begin
                  nxt.ref_b = user_sel_b;
               end else begin
                  nxt.ref_b = auto_b;
                  nxt.hold  = auto_hold;
               end
            end
            MODE_MAN_HOLD: begin
               if (user_ok) nxt.ref_b = user_sel_b;
               else         nxt.hold  = 1'b1;
            end
            MODE_MAN_FIXED: begin
               nxt.ref_b = user_sel_b;
            end
            default: begin
               nxt.ref_b = auto_b;
               nxt.hold  = auto_hold;
            end
         endcase
      end
   end

endmodule

// File: rtl/refsel_ctrl.sv
`timescale 1ns/1ps
// Two-input reference selection controller with registered outputs.
module refsel_ctrl
   import refsel_pkg::*;
#(
   parameter int PRIO_W        = 4,
   parameter bit SMALL_IS_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_a,
   input  logic              valid_b,
   input  logic [PRIO_W-1:0] prio_a,
   input  logic [PRIO_W-1:0] prio_b,
   input  logic              user_sel_b,
   input  logic [MODE_W-1:0] mode,
   input  logic              force_hold,
   input  logic              force_free,
   output logic              sel_b,
   output logic              in_holdover,
   output logic              in_freerun,
   output logic              switch_pulse
);

   logic       a_higher;
   logic       b_higher;
   logic       cur_idle;
   sel_state_t nxt;

   assign cur_idle = in_holdover | in_freerun;

   refsel_rank #(
      .PRIO_W        (PRIO_W),
      .SMALL_IS_HIGH (SMALL_IS_HIGH)
   ) i_rank (
      .prio_a   (prio_a),
      .prio_b   (prio_b),
      .a_higher (a_higher),
      .b_higher (b_higher)
   );

   refsel_policy i_policy (
      .valid_a    (valid_a),
      .valid_b    (valid_b),
      .a_higher   (a_higher),
      .b_higher   (b_higher),
      .user_sel_b (user_sel_b),
      .mode       (mode),
      .force_hold (force_hold),
      .force_free (force_free),
      .cur_b      (sel_b),
      .cur_idle   (cur_idle),
      .nxt        (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_b        <= 1'b0;
         in_holdover  <= 1'b0;
         in_freerun   <= 1'b0;
         switch_pulse <= 1'b0;
      end else begin
         sel_b        <= nxt.ref_b;
         in_holdover  <= nxt.hold;
         in_freerun   <= nxt.free;
         switch_pulse <= (nxt.ref_b != sel_b);
      end
   end

   logic auto_mode;
   logic cur_valid;
   logic unforced;
   assign auto_mode = (mode == MODE_AUTO_REV) || (mode == MODE_AUTO_NONREV);
   assign cur_valid = sel_b ? valid_b : valid_a;
   assign unforced  = !force_hold && !force_free;

   AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_holdover && in_freerun)); // R10
   AST_FREE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      force_free |=> (in_freerun && !in_holdover)); // R10
   AST_HOLD_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (force_hold && !force_free) |=> in_holdover); // R11
   AST_FORCE_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (force_hold || force_free) |=> $stable(sel_b)); // R11
   AST_NONREV_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUTO_NONREV && unforced && !cur_idle && cur_valid) |=> $stable(sel_b)); // R6
   AST_FIXED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_MAN_FIXED && unforced) |=> (sel_b == $past(user_sel_b) && !in_holdover)); // R9
   AST_NONE_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && unforced && !valid_a && !valid_b) |=> (in_holdover && $stable(sel_b))); // R12
   AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      switch_pulse == (sel_b != $past(sel_b))); // R13

endmodule

// File: tb/test_refsel_ctrl.sv
`timescale 1ns/1ps
module test_refsel_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       va = 1'b0, vb = 1'b0;
   logic [3:0] pa = 4'd0, pb = 4'd0;
   logic       usr = 1'b0;
   logic [2:0] mode = 3'd4;
   logic       fh = 1'b0, ff = 1'b0;
   logic       sel_b, in_holdover, in_freerun, switch_pulse;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   refsel_ctrl #(.PRIO_W(4), .SMALL_IS_HIGH(1'b1)) i_refsel_ctrl (
      .clk (clk), .rst_n (rst_n),
      .valid_a (va), .valid_b (vb), .prio_a (pa), .prio_b (pb),
      .user_sel_b (usr), .mode (mode),
      .force_hold (fh), .force_free (ff),
      .sel_b (sel_b), .in_holdover (in_holdover),
      .in_freerun (in_freerun), .switch_pulse (switch_pulse)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(string req, logic e_sel, logic e_hold, logic e_free, logic e_pulse);
      checks++;
      if ({sel_b, in_holdover, in_freerun, switch_pulse} !== {e_sel, e_hold, e_free, e_pulse}) begin
         fails++;
         $display("FAIL %s: sel_b/hold/free/pulse got %b%b%b%b expected %b%b%b%b", req,
                  sel_b, in_holdover, in_freerun, switch_pulse, e_sel, e_hold, e_free, e_pulse);
      end
   endtask

   task automatic park(logic b);
      mode = 3'd4; usr = b; fh = 1'b0; ff = 1'b0;
      step(); step();
   endtask

   task automatic t_reset();
      #1;
      expect_out("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_revertive();
      park(1'b0);
      mode = 3'd0; va = 1; vb = 1; pa = 4'd2; pb = 4'd1; usr = 1'b0;
      step(); expect_out("R2 higher priority B chosen, user ignored", 1, 0, 0, 1);
      vb = 0;
      step(); expect_out("R2 only A valid", 0, 0, 0, 1);
      vb = 1;
      step(); expect_out("R3 revert to B", 1, 0, 0, 1);
      step(); expect_out("R13 pulse lasts one cycle", 1, 0, 0, 0);
   endtask

   task automatic t_tie();
      park(1'b1);
      mode = 3'd0; va = 1; vb = 1; pa = 4'd3; pb = 4'd3;
      step(); expect_out("R4 tie keeps B", 1, 0, 0, 0);
      fh = 1;
      step(); expect_out("R11 forced holdover", 1, 1, 0, 0);
      fh = 0;
      step(); expect_out("R5 fresh tie picks A", 0, 0, 0, 1);
   endtask

   task automatic t_nonrev();
      park(1'b0);
      mode = 3'd1; va = 1; vb = 1; pa = 4'd5; pb = 4'd1; usr = 1'b1;
      step(); expect_out("R6 stays on valid A", 0, 0, 0, 0);
      va = 0;
      step(); expect_out("R6 moves to B when A lost", 1, 0, 0, 1);
      va = 1; pa = 4'd0;
      step(); expect_out("R6 no return to A", 1, 0, 0, 0);
   endtask

   task automatic t_fallback();
      park(1'b0);
      mode = 3'd2; usr = 1'b1; va = 1; vb = 1; pa = 4'd1; pb = 4'd9;
      step(); expect_out("R7 user B despite low priority", 1, 0, 0, 1);
      vb = 0;
      step(); expect_out("R7 fall back to A", 0, 0, 0, 1);
      vb = 1;
      step(); expect_out("R7 return to user B", 1, 0, 0, 1);
      va = 0; vb = 0;
      step(); expect_out("R7 none valid holdover", 1, 1, 0, 0);
   endtask

   task automatic t_manhold();
      park(1'b1);
      mode = 3'd3; usr = 1'b1; va = 1; vb = 1;
      step(); expect_out("R8 user B used", 1, 0, 0, 0);
      vb = 0;
      step(); expect_out("R8 holdover, A not taken", 1, 1, 0, 0);
      vb = 1;
      step(); expect_out("R8 user B back", 1, 0, 0, 0);
   endtask

   task automatic t_manfixed();
      park(1'b0);
      va = 0; vb = 1; pb = 4'd0;
      step(); expect_out("R9 invalid A still used", 0, 0, 0, 0);
      usr = 1'b1;
      step(); expect_out("R9 follows user B", 1, 0, 0, 1);
      vb = 0;
      step(); expect_out("R9 invalid B still used", 1, 0, 0, 0);
   endtask

   task automatic t_forces();
      mode = 3'd0; va = 1; vb = 1; pa = 4'd1; pb = 4'd2;
      step(); expect_out("R2 A higher priority", 0, 0, 0, 1);
      ff = 1;
      step(); expect_out("R10 free run", 0, 0, 1, 0);
      fh = 1;
      step(); expect_out("R10 free run beats holdover", 0, 0, 1, 0);
      ff = 0;
      step(); expect_out("R11 holdover force", 0, 1, 0, 0);
      pa = 4'd9;
      step(); expect_out("R11 index held while forced", 0, 1, 0, 0);
      fh = 0;
      step(); expect_out("R3 released to better B", 1, 0, 0, 1);
   endtask

   task automatic t_none();
      mode = 3'd0; va = 0; vb = 0;
      step(); expect_out("R12 revertive none valid", 1, 1, 0, 0);
      mode = 3'd1;
      step(); expect_out("R12 non-revertive none valid", 1, 1, 0, 0);
      va = 1;
      step(); expect_out("R12 leave holdover to A", 0, 0, 0, 1);
   endtask

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_revertive();
      t_tie();
      t_nonrev();
      t_fallback();
      t_manhold();
      t_manfixed();
      t_forces();
      t_none();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule